// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block sits beside the register file of a 16550-style serial port and decides which interrupt the port reports. Every cycle it qualifies five interrupt sources against the interrupt enable bits, picks the one with the highest fixed priority, and registers the result. The registered result drives an 8-bit identification byte and a level interrupt request. The identification byte carries the priority code in its low nibble and a FIFO-mode marker in its top two bits.

The transmit-empty source has no status bit of its own in the line status register, so the block keeps it in a small two-state machine. Its states are `TXE_IDLE` (no transmit-empty interrupt owed) and `TXE_ARMED` (one is owed). The `IDLE -> ARMED` transition fires when the transmitter drains, or when the enable register is written while the holding register is empty. The `ARMED -> IDLE` transition fires when the identification byte is read or the holding register is written, unless an arming event happens in the same cycle. The surrounding register file supplies the strobes, the status bits, the receive FIFO count and the trigger level. Shifting, the FIFOs and the baud timing live elsewhere.

Top module: `uart_int_ident`

## Requirements
- R1: After reset, `iid` reads 0x01 and `irq` is low, and the transmit-empty machine is in `TXE_IDLE`.
- R2: The line-status source is pending when `ier[2]` is set and any bit of `line_err` is set. It has the highest priority and shows code 0x6.
- R3: The character-timeout source is pending when `ier[0]` and `rto_pend` are both set, and shows code 0xC. It ranks below line status and above every other source. It is masked when `ier[0]` is clear.
- R4: The received-data source shows code 0x4 when `ier[0]` and `rx_ready` are set. With `fifo_on` high it also needs `rx_count >= rx_trigger`. With `fifo_on` low, `rx_ready` alone is enough. It ranks above transmit-empty and modem status.
- R5: The transmit-empty source shows code 0x2 when `ier[1]` is set and the machine is in `TXE_ARMED`. Clearing `ier[1]` masks it without disarming the machine.
- R6: The modem-status source shows code 0x0 when `ier[3]` is set and any bit of `msr_delta` is set. It has the lowest priority.
- R7: With no source pending, `iid[3:0]` is 0x1. `irq` is high exactly when `iid[3:0]` differs from 0x1.
- R8: `iid[7:6]` reads 11 when `fifo_on` is high and 00 when it is low. `iid[5:4]` always reads 00.
- R9: A `tx_drained` pulse arms the transmit-empty machine. An `ier_wr` pulse arms it only while `holding_empty` is high. An `ier_wr` pulse with `holding_empty` low has no effect.
- R10: An `iid_rd` or `thr_wr` pulse disarms the transmit-empty machine. When an arming event and a disarming event fall in the same cycle, the machine ends up `TXE_ARMED`.
- R11: `iid` and `irq` are registered. A change on a source input appears after the next rising clock edge. A transmit-empty event appears after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Enable bits: 0 receive data/timeout, 1 transmit empty, 2 line status, 3 modem status |
| line_err | input | 4 | Overrun, parity, framing and break flags (any set raises line status) |
| rx_ready | input | 1 | Received data is available |
| fifo_on | input | 1 | FIFO mode is enabled |
| rx_count | input | CNT_W | Current receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rto_pend | input | 1 | Character timeout is pending |
| msr_delta | input | 4 | Modem status change flags |
| tx_drained | input | 1 | Pulse: the transmitter has emptied |
| holding_empty | input | 1 | Transmit holding register is empty |
| ier_wr | input | 1 | Pulse: the enable register is written |
| thr_wr | input | 1 | Pulse: the holding register is written |
| iid_rd | input | 1 | Pulse: the identification byte is read |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the priority boundaries.

- If line status does not beat the timeout, a vector with every source active shows 0xC instead of 0x6.
- If the timeout ignores `ier[0]`, a vector with `ier[0]` clear and the timeout pending shows 0xC instead of no interrupt.
- If the trigger compare is off by one, a vector with the count equal to the trigger stays quiet, or a vector with the count one below the trigger fires early.

The transmit-empty machine is driven through every transition:

- An enable write with the holding register busy must not arm it.
- A read in the same cycle as a drain must leave it armed.
- Masking `ier[1]` must hide the source without losing it. A design that disarms on masking shows no interrupt when the enable bit returns.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    // Source indices in priority order, 0 = highest.
    localparam int SRC_N     = 5;
    localparam int SRC_LINE  = 0;
    localparam int SRC_TMO   = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_TXE   = 3;
    localparam int SRC_MODEM = 4;

    // Enable bit positions (decoded by software, so fixed).
    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [3:0] {
        IID_MODEM = 4'h0,
        IID_NONE  = 4'h1,
        IID_TXE   = 4'h2,
        IID_RXD   = 4'h4,
        IID_LINE  = 4'h6,
        IID_TMO   = 4'hC
    } iid_code_e;

    typedef enum logic {
        TXE_IDLE  = 1'b0,
        TXE_ARMED = 1'b1
    } txe_state_e;

    function automatic iid_code_e code_of(input int idx);
        iid_code_e c;
        case (idx)
            SRC_LINE:  c = IID_LINE;
            SRC_TMO:   c = IID_TMO;
            SRC_RXD:   c = IID_RXD;
            SRC_TXE:   c = IID_TXE;
            default:   c = IID_MODEM;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uirq_txe_flag.sv
module uirq_txe_flag
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_drained,
    input  logic ier_wr,
    input  logic holding_empty,
    input  logic thr_wr,
    input  logic iid_rd,
    output logic pending
);

    txe_state_e state_q, state_d;
    logic       arm_ev, disarm_ev;

    assign arm_ev    = tx_drained | (ier_wr & holding_empty);
    assign disarm_ev = thr_wr | iid_rd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE:  if (arm_ev) state_d = TXE_ARMED;
            TXE_ARMED: if (disarm_ev && !arm_ev) state_d = TXE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == TXE_ARMED);
    end

    assert_drain_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drained |=> pending);

    assert_read_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && !tx_drained && !ier_wr) |=> !pending);

    assert_busy_ier_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && ier_wr && !holding_empty && !tx_drained) |=> !pending);

endmodule

// File: rtl/uirq_src_qual.sv
module uirq_src_qual
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rto_pend,
    input  logic             txe_pend,
    input  logic [3:0]       msr_delta,
    output logic [SRC_N-1:0] req
);

    logic level_met;

    always_comb begin
        level_met      = !fifo_on || (rx_count >= rx_trigger);
        req            = '0;
        req[SRC_LINE]  = ier[EN_LINE]  && (|line_err);
        req[SRC_TMO]   = ier[EN_RXD]   && rto_pend;
        req[SRC_RXD]   = ier[EN_RXD]   && rx_ready && level_met;
        req[SRC_TXE]   = ier[EN_TXE]   && txe_pend;
        req[SRC_MODEM] = ier[EN_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    output iid_code_e        code
);

    // Walk from lowest to highest priority so the highest one wins.
    always_comb begin
        code = IID_NONE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) code = code_of(i);
        end
    end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uirq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rto_pend,
    input  logic [3:0]       msr_delta,
    input  logic             tx_drained,
    input  logic             holding_empty,
    input  logic             ier_wr,
    input  logic             thr_wr,
    input  logic             iid_rd,
    output logic [7:0]       iid,
    output logic             irq
);

    logic             txe_pend;
    logic [SRC_N-1:0] req;
    iid_code_e        code;

    uirq_txe_flag u_txe (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_drained    (tx_drained),
        .ier_wr        (ier_wr),
        .holding_empty (holding_empty),
        .thr_wr        (thr_wr),
        .iid_rd        (iid_rd),
        .pending       (txe_pend)
    );

    uirq_src_qual #(.CNT_W(CNT_W)) u_qual (
        .ier        (ier),
        .line_err   (line_err),
        .rx_ready   (rx_ready),
        .fifo_on    (fifo_on),
        .rx_count   (rx_count),
        .rx_trigger (rx_trigger),
        .rto_pend   (rto_pend),
        .txe_pend   (txe_pend),
        .msr_delta  (msr_delta),
        .req        (req)
    );

    uirq_prio u_prio (
        .req  (req),
        .code (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iid <= {4'h0, IID_NONE};
            irq <= 1'b0;
        end else begin
            iid <= {{2{fifo_on}}, 2'b00, code};
            irq <= (code != IID_NONE);
        end
    end

    assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req[SRC_LINE] |=> (iid[3:0] == 4'h6));

    assert_tmo_beats_rxd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req[SRC_LINE] && req[SRC_TMO]) |=> (iid[3:0] == 4'hC));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (iid[3:0] == 4'h1 && !irq));

    assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid[3:0] != 4'h1));

    assert_fifo_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on |=> (iid[7:6] == 2'b11));

    assert_gap_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iid[5:4] == 2'b00);

endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ier = '0, line_err = '0, msr_delta = '0;
    logic       rx_ready = 0, fifo_on = 0, rto_pend = 0;
    logic [4:0] rx_count = '0, rx_trigger = '0;
    logic       tx_drained = 0, holding_empty = 0, ier_wr = 0, thr_wr = 0, iid_rd = 0;
    logic [7:0] iid;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_int_ident i_uart_int_ident (
        .clk(clk), .rst_n(rst_n), .ier(ier), .line_err(line_err),
        .rx_ready(rx_ready), .fifo_on(fifo_on), .rx_count(rx_count),
        .rx_trigger(rx_trigger), .rto_pend(rto_pend), .msr_delta(msr_delta),
        .tx_drained(tx_drained), .holding_empty(holding_empty), .ier_wr(ier_wr),
        .thr_wr(thr_wr), .iid_rd(iid_rd), .iid(iid), .irq(irq)
    );

    // {req#, ier, line_err, rx_ready, fifo_on, rx_count, rx_trigger, rto_pend, msr_delta, expected iid}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {4'd7,  4'hF, 4'h0, 1'b0, 1'b0, 5'd0, 5'd0,  1'b0, 4'h0, 8'h01}, // R7 quiet
        {4'd2,  4'h4, 4'h2, 1'b0, 1'b0, 5'd0, 5'd0,  1'b0, 4'h0, 8'h06}, // R2 alone
        {4'd2,  4'hF, 4'h8, 1'b1, 1'b1, 5'd8, 5'd4,  1'b1, 4'hF, 8'hC6}, // R2 beats all, R8
        {4'd3,  4'hB, 4'h8, 1'b1, 1'b1, 5'd8, 5'd4,  1'b1, 4'h0, 8'hCC}, // R3 over rx data
        {4'd3,  4'hE, 4'h0, 1'b1, 1'b1, 5'd8, 5'd4,  1'b1, 4'h0, 8'hC1}, // R3 masked by ier[0]
        {4'd4,  4'h1, 4'h0, 1'b1, 1'b1, 5'd4, 5'd4,  1'b0, 4'h0, 8'hC4}, // R4 count == trigger
        {4'd4,  4'h1, 4'h0, 1'b1, 1'b1, 5'd3, 5'd4,  1'b0, 4'h0, 8'hC1}, // R4 count below
        {4'd4,  4'h1, 4'h0, 1'b1, 1'b0, 5'd0, 5'd14, 1'b0, 4'h0, 8'h04}, // R4 no FIFO
        {4'd6,  4'h8, 4'h0, 1'b0, 1'b0, 5'd0, 5'd0,  1'b0, 4'h4, 8'h00}, // R6 modem
        {4'd6,  4'h7, 4'h0, 1'b0, 1'b0, 5'd0, 5'd0,  1'b0, 4'hF, 8'h01}, // R6 masked
        {4'd4,  4'h9, 4'h0, 1'b1, 1'b0, 5'd0, 5'd0,  1'b0, 4'h1, 8'h04}, // R4 above modem
        {4'd2,  4'hF, 4'h1, 1'b0, 1'b0, 5'd0, 5'd0,  1'b0, 4'h0, 8'h06}  // R2 overrun only
    };

    task automatic chk(input logic [7:0] exp, input string tag);
        logic exp_irq;
        exp_irq = (exp[3:0] != 4'h1);
        checks++;
        if (iid !== exp || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                     tag, iid, irq, exp, exp_irq);
        end
    endtask

    // Pulse strobes for one cycle, then wait for flag and output registers.
    task automatic strobe(input logic drn, input logic iw, input logic tw, input logic rd);
        tx_drained = drn; ier_wr = iw; thr_wr = tw; iid_rd = rd;
        @(negedge clk);
        tx_drained = 0; ier_wr = 0; thr_wr = 0; iid_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                chk(8'h01, "R1 reset state");
                @(negedge clk);
                chk(8'h01, "R1 flag idle after reset");

                for (int k = 0; k < NV; k++) begin
                    {ier, line_err, rx_ready, fifo_on, rx_count, rx_trigger,
                     rto_pend, msr_delta} = VEC[k][32:8];
                    @(negedge clk);
                    chk(VEC[k][7:0], $sformatf("R%0d vector %0d", VEC[k][36:33], k));
                end

                // R11: output holds until the next edge
                ier = 4'h4; line_err = 4'h4; rx_ready = 0; fifo_on = 0;
                rto_pend = 0; msr_delta = 4'h0;
                @(negedge clk);
                chk(8'h06, "R11 settled");
                line_err = 4'h0;
                #1;
                chk(8'h06, "R11 held before edge");
                @(negedge clk);
                chk(8'h01, "R11 after edge");

                // Transmit-empty machine
                ier = 4'h2;
                @(negedge clk);
                strobe(1, 0, 0, 0);
                chk(8'h02, "R9 drain arms");
                strobe(0, 0, 0, 1);
                chk(8'h01, "R10 read disarms");
                holding_empty = 0;
                strobe(0, 1, 0, 0);
                chk(8'h01, "R9 ier write while busy ignored");
                holding_empty = 1;
                strobe(0, 1, 0, 0);
                chk(8'h02, "R9 ier write while empty arms");
                strobe(0, 0, 1, 0);
                chk(8'h01, "R10 holding write disarms");
                strobe(1, 0, 0, 1);
                chk(8'h02, "R10 arm wins over read");
                ier = 4'hA; msr_delta = 4'h1;
                @(negedge clk);
                chk(8'h02, "R5 above modem");
                ier = 4'h8;
                @(negedge clk);
                chk(8'h00, "R5 masked, modem shows");
                ier = 4'h2; msr_delta = 4'h0;
                @(negedge clk);
                chk(8'h02, "R5 flag kept while masked");
                strobe(0, 0, 0, 1);
                chk(8'h01, "R10 final read");
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule